// File: doc/BRIEF.md
# Moded Float Immediate Loader

This unit computes the write-back value for a single "load float immediate" operation. It takes a 32-bit immediate, a 2-bit mode and the current contents of the 64-bit destination float register. It returns the 64-bit word to write, together with a write strobe. Register read and write-back are modelled as plain buses. The datapath is purely combinational, so the result follows the operands in the same cycle.

The mode chooses one of four uses of the same immediate:
- **Widen:** convert a single-precision constant to double precision.
- **Assemble:** build a full double from two 32-bit halves over two operations. The first is a widen of the high word. The second narrows the register back to that word and appends the low word.
- **Low half:** zero-extend a raw 32-bit pattern, such as a half, bfloat16 or single value, into the low half.
- **Splat:** copy the pattern into both halves.

The operation behaves like a register move. It raises no floating-point exceptions and keeps every NaN payload, including signalling NaNs, bit for bit.

Top module: `fli_unit`

## Requirements
- R1: With mode_i = 2'b00 and a normal single in imm_i (exponent field 1..254), res_o is {sign, exponent+896 as 11 bits, imm_i[22:0], 29 zero bits}; a signed zero widens to {sign, 63 zero bits}.
- R2: With mode_i = 2'b00 and an all-ones single exponent (infinity or any NaN, signalling included), res_o holds the sign, exponent 11'h7FF, imm_i[22:0] unchanged in bits 51:29, and zeros in bits 28:0.
- R3: With mode_i = 2'b00 and a single subnormal (exponent 0, fraction nonzero), res_o is the normalised double: exponent 897-k, fraction bits 51:29 equal to the fraction shifted left by k with its leading one dropped, where k is the smallest shift that sets bit 23.
- R4: With mode_i = 2'b01, res_o[31:0] equals imm_i, and res_o[63:32] is the narrowed register. When the register exponent is above 896, or bits 62:0 are all zero, the narrowed word is {frt_i[63], frt_i[62], frt_i[58:29]}.
- R5: With mode_i = 2'b01 and a register exponent E in 874..896, the narrowed upper word is {sign, 8'h00, ({1, frt_i[51:29]} >> (897-E))[22:0]}.
- R6: A mode 2'b00 operation with word X, whose result is fed back as frt_i to a mode 2'b01 operation with word Y, yields exactly {X, Y} for every 32-bit X, including NaNs and subnormals.
- R7: With mode_i = 2'b10, res_o is {32'h0, imm_i}.
- R8: With mode_i = 2'b11, res_o is {imm_i, imm_i}.
- R9: wr_en_o equals valid_i in every mode. In modes 2'b00, 2'b10 and 2'b11, the value of frt_i has no effect on res_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| valid_i | input | 1 | Operation issued this cycle |
| mode_i | input | 2 | 00 widen, 01 assemble, 10 low half, 11 splat |
| imm_i | input | 32 | Immediate word |
| frt_i | input | 64 | Current destination register value |
| res_o | output | 64 | Value to write back |
| wr_en_o | output | 1 | Write strobe for the destination register |

## Verification
Every result is due in the same cycle as its operands, because no register lies between imm_i, mode_i or frt_i and res_o. The bench therefore drives the operands a few nanoseconds after a clock edge and samples res_o later in the same cycle, before the next edge.

For the two-step assembly, the bench latches the first result and presents it as frt_i in the following cycle. It then compares that second result within its own cycle. The bound checker evaluates its immediate assertions whenever the combinational outputs settle.

// File: rtl/flimm_pkg.sv
package flimm_pkg;

  localparam int SP_W   = 32;
  localparam int DP_W   = 64;
  localparam int SP_FW  = 23;
  localparam int DP_FW  = 52;
  localparam int PAD_W  = DP_FW - SP_FW;   // 29
  localparam int EXP_BIAS_DIFF = 896;       // 1023 - 127

  typedef enum logic [1:0] {
    FLI_WIDEN  = 2'b00,
    FLI_ASSEM  = 2'b01,
    FLI_LOW    = 2'b10,
    FLI_SPLAT  = 2'b11
  } fli_mode_e;

  // Position of the highest set bit of a nonzero single fraction.
  function automatic logic [4:0] lead_one(input logic [SP_FW-1:0] f);
    logic [4:0] p;
    p = 5'd0;
    for (int i = 0; i < SP_FW; i++) begin
      if (f[i]) p = 5'(i);
    end
    return p;
  endfunction

  // Single word to double word, subnormals normalised, no exceptions.
  function automatic logic [DP_W-1:0] sp_to_dp(input logic [SP_W-1:0] w);
    logic            s;
    logic [7:0]      e;
    logic [SP_FW-1:0] f;
    logic [4:0]      p;
    logic [45:0]     sh;
    logic [10:0]     de;
    s = w[31];
    e = w[30:23];
    f = w[22:0];
    if (e == 8'hFF) begin
      return {s, 11'h7FF, f, {PAD_W{1'b0}}};
    end else if (e != 8'h00) begin
      de = 11'(e) + 11'(EXP_BIAS_DIFF);
      return {s, de, f, {PAD_W{1'b0}}};
    end else if (f == '0) begin
      return {s, {(DP_W-1){1'b0}}};
    end else begin
      p  = lead_one(f);
      sh = 46'(f) << (5'd23 - p);
      de = 11'd874 + 11'(p);
      return {s, de, sh[22:0], {PAD_W{1'b0}}};
    end
  endfunction

  // Double word to single word, store-style truncating selection.
  function automatic logic [SP_W-1:0] dp_to_sp(input logic [DP_W-1:0] d);
    logic [10:0] e;
    logic [23:0] m;
    logic [10:0] amt;
    e = d[62:52];
    if (e > 11'd896 || d[62:0] == '0) begin
      return {d[63], d[62], d[58:29]};
    end else if (e >= 11'd874) begin
      m   = {1'b1, d[51:29]};
      amt = 11'd897 - e;
      m   = m >> amt[4:0];
      return {d[63], 8'h00, m[22:0]};
    end else begin
      return {d[63], d[62], d[58:29]};
    end
  endfunction

endpackage

// File: rtl/fli_widen.sv
module fli_widen
  import flimm_pkg::*;
(
  input  logic [SP_W-1:0] word_i,
  output logic [DP_W-1:0] dbl_o
);
  always_comb dbl_o = sp_to_dp(word_i);
endmodule

// File: rtl/fli_narrow.sv
module fli_narrow
  import flimm_pkg::*;
(
  input  logic [DP_W-1:0] dbl_i,
  output logic [SP_W-1:0] word_o
);
  always_comb word_o = dp_to_sp(dbl_i);
endmodule

// File: rtl/fli_select.sv
module fli_select
  import flimm_pkg::*;
(
  input  logic [1:0]      mode_i,
  input  logic [SP_W-1:0] imm_i,
  input  logic [DP_W-1:0] widened_i,
  input  logic [SP_W-1:0] narrowed_i,
  output logic [DP_W-1:0] res_o
);
  always_comb begin
    unique case (fli_mode_e'(mode_i))
      FLI_WIDEN: res_o = widened_i;
      FLI_ASSEM: res_o = {narrowed_i, imm_i};
      FLI_LOW:   res_o = {{SP_W{1'b0}}, imm_i};
      default:   res_o = {imm_i, imm_i};
    endcase
  end
endmodule

// File: rtl/fli_unit.sv
module fli_unit
  import flimm_pkg::*;
(
  input  logic            valid_i,
  input  logic [1:0]      mode_i,
  input  logic [31:0]     imm_i,
  input  logic [63:0]     frt_i,
  output logic [63:0]     res_o,
  output logic            wr_en_o
);
  logic [DP_W-1:0] widen_word;
  logic [SP_W-1:0] narrow_word;

  fli_widen u_widen (
    .word_i (imm_i),
    .dbl_o  (widen_word)
  );

  fli_narrow u_narrow (
    .dbl_i  (frt_i),
    .word_o (narrow_word)
  );

  fli_select u_sel (
    .mode_i     (mode_i),
    .imm_i      (imm_i),
    .widened_i  (widen_word),
    .narrowed_i (narrow_word),
    .res_o      (res_o)
  );

  assign wr_en_o = valid_i;
endmodule

// File: rtl/fli_unit_chk.sv
module fli_unit_chk (
  input logic        valid_i,
  input logic [1:0]  mode_i,
  input logic [31:0] imm_i,
  input logic [63:0] frt_i,
  input logic [63:0] res_o,
  input logic        wr_en_o,
  input logic [63:0] widen_word,
  input logic [31:0] narrow_word
);
  always_comb begin
    if (mode_i == 2'b00 && imm_i[30:23] == 8'hFF) begin
      // R2
      special_keep_chk: assert (res_o[62:52] == 11'h7FF && res_o[51:29] == imm_i[22:0]
                                && res_o[63] == imm_i[31]);
    end
    if (mode_i == 2'b00 && imm_i[30:23] == 8'h00 && imm_i[22:0] != 23'h0) begin
      // R3
      subn_norm_chk: assert (res_o[62:52] >= 11'd874 && res_o[62:52] <= 11'd896
                             && res_o[28:0] == 29'h0);
    end
    if (mode_i == 2'b00 && imm_i[30:23] != 8'h00 && imm_i[30:23] != 8'hFF) begin
      // R1
      normal_pad_chk: assert (res_o[28:0] == 29'h0 && res_o[51:29] == imm_i[22:0]);
    end
    if (mode_i == 2'b00) begin
      // R6
      round_trip_chk: assert (narrow_word == imm_i || frt_i != widen_word);
    end
    if (mode_i == 2'b01) begin
      // R4
      assem_low_chk: assert (res_o[31:0] == imm_i);
    end
    if (mode_i == 2'b10) begin
      // R7
      low_zero_chk: assert (res_o == {32'h0, imm_i});
    end
    if (mode_i == 2'b11) begin
      // R8
      splat_equal_chk: assert (res_o[63:32] == res_o[31:0]);
    end
    // R9
    strobe_chk: assert (wr_en_o == valid_i);
  end
endmodule

bind fli_unit fli_unit_chk u_chk (
  .valid_i     (valid_i),
  .mode_i      (mode_i),
  .imm_i       (imm_i),
  .frt_i       (frt_i),
  .res_o       (res_o),
  .wr_en_o     (wr_en_o),
  .widen_word  (widen_word),
  .narrow_word (narrow_word)
);

// File: tb/fli_unit_tb.sv
module fli_unit_tb;
  logic        clk = 1'b0;
  logic        valid_i;
  logic [1:0]  mode_i;
  logic [31:0] imm_i;
  logic [63:0] frt_i;
  logic [63:0] res_o;
  logic        wr_en_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  fli_unit u_dut (
    .valid_i (valid_i),
    .mode_i  (mode_i),
    .imm_i   (imm_i),
    .frt_i   (frt_i),
    .res_o   (res_o),
    .wr_en_o (wr_en_o)
  );

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Operands change 3 ns after a rising edge; the combinational result is read 8 ns later.
  task automatic apply(input logic v, input logic [1:0] m, input logic [31:0] w, input logic [63:0] r);
    @(posedge clk);
    #3;
    valid_i = v; mode_i = m; imm_i = w; frt_i = r;
    #8;
  endtask

  // Bench restatement of widening: shift-count form.
  function automatic logic [63:0] ref_widen(input logic [31:0] w);
    logic [7:0]  e;
    logic [23:0] m;
    int          k;
    e = w[30:23];
    if (e == 8'hFF) return {w[31], 11'h7FF, w[22:0], 29'h0};
    if (e != 0)     return {w[31], 11'(int'(e) - 127 + 1023), w[22:0], 29'h0};
    if (w[22:0] == 0) return {w[31], 63'h0};
    m = {1'b0, w[22:0]};
    k = 0;
    while (m[23] == 1'b0) begin
      m = m << 1;
      k++;
    end
    return {w[31], 11'(897 - k), m[22:0], 29'h0};
  endfunction

  task automatic pair(input logic [31:0] x, input logic [31:0] y, input string tag);
    logic [63:0] held;
    apply(1'b1, 2'b00, x, {$urandom, $urandom});
    check64({tag, " R1/R2/R3 widen"}, res_o, ref_widen(x));
    held = res_o;
    apply(1'b1, 2'b01, y, held);
    // R6
    check64({tag, " R6 assemble"}, res_o, {x, y});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [22:0] fr [7];
    valid_i = 0; mode_i = 0; imm_i = 0; frt_i = 0;
    #1;
    // R9: idle strobe
    check64("R9 idle strobe", {63'h0, wr_en_o}, 64'h0);

    fr[0] = 23'h0; fr[1] = 23'h1; fr[2] = 23'h400000; fr[3] = 23'h7FFFFF;
    fr[4] = 23'h155555; fr[5] = 23'h2AAAAA; fr[6] = 23'h000100;

    // Exponent sweep, both signs, several fractions: R1 R2 R3 R6
    for (int e = 0; e < 256; e++) begin
      for (int s = 0; s < 2; s++) begin
        for (int j = 0; j < 7; j++) begin
          pair({1'(s), 8'(e), fr[j]}, $urandom, "sweep");
        end
      end
    end

    // Every single-bit subnormal fraction: R3
    for (int b = 0; b < 23; b++) begin
      apply(1'b1, 2'b00, 32'(1) << b, 64'hFFFF_FFFF_FFFF_FFFF);
      check64("R3 subnormal bit", res_o, ref_widen(32'(1) << b));
    end
    apply(1'b1, 2'b00, 32'h0000_0001, 64'h0);
    check64("R3 min subnormal", res_o, 64'h36A0_0000_0000_0000);
    apply(1'b1, 2'b00, 32'h7F80_0001, 64'h0);
    check64("R2 signalling NaN", res_o, 64'h7FF0_0000_2000_0000);
    apply(1'b1, 2'b00, 32'h3F80_0000, 64'h0);
    check64("R1 one", res_o, 64'h3FF0_0000_0000_0000);

    // Random full doubles with forced NaN / subnormal / inf classes: R6
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] x;
      x = $urandom;
      case (i % 4)
        0: x[30:23] = 8'hFF;
        1: x[30:23] = 8'h00;
        default: ;
      endcase
      pair(x, $urandom, "random");
    end

    // R4 direct narrowing
    apply(1'b1, 2'b01, 32'hDEAD_BEEF, 64'h3FF0_0000_0000_0000);
    check64("R4 narrow one", res_o, 64'h3F80_0000_DEAD_BEEF);
    apply(1'b1, 2'b01, 32'h1234_5678, 64'h8000_0000_0000_0000);
    check64("R4 narrow neg zero", res_o, 64'h8000_0000_1234_5678);
    // R5 denormalising range
    apply(1'b1, 2'b01, 32'h0, 64'h3800_0000_0000_0000);
    check64("R5 exp 896", res_o, 64'h0040_0000_0000_0000);
    apply(1'b1, 2'b01, 32'h0, {1'b1, 11'd874, 52'h0});
    check64("R5 exp 874", res_o, 64'h8000_0001_0000_0000);
    apply(1'b1, 2'b01, 32'h5, {1'b0, 11'd895, 52'h8_0000_0000_0000});
    check64("R5 exp 895", res_o, 64'h0030_0000_0000_0005);

    // R7 R8 R9 with varied register contents
    for (int i = 0; i < 64; i++) begin
      logic [31:0] w;
      logic [63:0] r;
      w = $urandom;
      r = {$urandom, $urandom};
      apply(1'b1, 2'b10, w, r);
      check64("R7 low half", res_o, {32'h0, w});
      apply(1'b0, 2'b10, w, ~r);
      check64("R9 low ignores frt", res_o, {32'h0, w});
      check64("R9 strobe off", {63'h0, wr_en_o}, 64'h0);
      apply(1'b1, 2'b11, w, r);
      check64("R8 splat", res_o, {w, w});
      check64("R9 strobe on", {63'h0, wr_en_o}, 64'h1);
      apply(1'b1, 2'b11, w, ~r);
      check64("R9 splat ignores frt", res_o, {w, w});
      apply(1'b1, 2'b00, w, ~r);
      check64("R9 widen ignores frt", res_o, ref_widen(w));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule